// File: doc/BRIEF.md
# Nibble-Command Register Slave for a Host Parallel Data Port

This block sits on the device side of an 8-bit host output port and turns the byte values seen there into accesses to a small bank of 8-bit registers. Each host byte carries an opcode in bits 7:5, a nibble selector in bit 4 and a four-bit operand in bits 3:0. The operand is an address or a data nibble, depending on the opcode. The host frames every access with an end-of-command byte. It sets a write or read address, then moves data four bits at a time. Read data comes back on a 5-bit status return bus.

The host port has no strobe. The block treats a byte as a new event only when the synchronised value differs from the one before it. A host may therefore repeat any byte, for example to suit a slow or skewed bus, without side effects. The port has no valid/ready handshake and cannot push back. The host must hold each byte for at least five clock cycles, and the block consumes every distinct value it sees.

Top module: `pp_nib_slave`

## Requirements
- R1: Any byte whose bits 7:5 are 111 ends the command. It discards the latched write address and the read selection, and within four clock cycles the status return reads 0.
- R2: A byte with bits 7:5 = 010, received while no write address is held, latches bits 3:0 as the write address. Further 010 bytes do not change that address until the next end byte.
- R3: While a write address is held, a byte with bits 7:5 = 000 that follows a byte with a nonzero opcode writes its bits 3:0 into the addressed register. Bit 4 = 0 selects bits 3:0 of the register and bit 4 = 1 selects bits 7:4.
- R4: While a write address is held, a byte with bits 7:5 = 000 and bit 4 = 1 that follows a byte with bits 7:5 = 000 and bit 4 = 0 writes its bits 3:0 into bits 7:4 of the register. This completes a byte write in the order low nibble, then high nibble.
- R5: A byte with bits 7:5 = 110 selects register bits 3:0 for reading, and bit 4 picks the high nibble (1) or the low nibble (0). Within four cycles, status bits 3:0 show that nibble and status bit 4 reads 1.
- R6: A byte held for any length of time, or sent twice in a row, has the same effect as the same byte sent once.
- R7: A data byte (bits 7:5 = 000) that arrives with no write address held since the last end byte leaves every register unchanged.
- R8: After reset, all sixteen registers read 0x00 and the status return is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data | input | 8 | Host data-port byte, asynchronous to clk |
| stat_o | output | 5 | Bit 4: a read is selected; bits 3:0: selected nibble |

## Verification
The assertions assume that the host holds each byte long enough for the two-flop synchroniser to pass one clean value. They also assume that any change on the port is one distinct event. The stimulus changes the port only on the falling clock edge and then holds it for seven cycles. It builds only legal framed sequences, and it inserts repeated bytes on purpose. A random byte that happens to equal its predecessor is also legal. Both cases exercise the change detector without breaking these assumptions.

// File: rtl/pp_nib_pkg.sv
package pp_nib_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_DATA  = 3'b000,
    OP_WADDR = 3'b010,
    OP_RADDR = 3'b110,
    OP_END   = 3'b111
  } pp_op_e;
endpackage

// File: rtl/pp_nib_sync.sv
module pp_nib_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic         fresh
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign cur   = stab_q;
  assign prev  = prev_q;
  assign fresh = (stab_q != prev_q);

  // a held value produces no further event
  assert_held_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> ($stable(cur) |-> !fresh));
endmodule

// File: rtl/pp_nib_decode.sv
module pp_nib_decode
  import pp_nib_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cur,
  input  logic [BYTE_W-1:0] prev,
  input  logic              fresh,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              wr_hi,
  output logic [NIB_W-1:0]  wr_data,
  output logic              rd_act,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_hi
);
  pp_op_e op_cur, op_prev;
  logic   addr_ok_q;
  logic [AW-1:0] wa_q;
  logic hi_rise, opcode_drop;

  always_comb begin
    op_cur      = pp_op_e'(cur[7:5]);
    op_prev     = pp_op_e'(prev[7:5]);
    opcode_drop = (op_prev != OP_DATA);
    hi_rise     = cur[4] && !prev[4];
    wr_en       = fresh && addr_ok_q && (op_cur == OP_DATA) && (opcode_drop || hi_rise);
    wr_addr     = wa_q;
    wr_hi       = cur[4];
    wr_data     = cur[NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_ok_q <= 1'b0;
      wa_q      <= '0;
      rd_act    <= 1'b0;
      rd_addr   <= '0;
      rd_hi     <= 1'b0;
    end else if (fresh) begin
      case (op_cur)
        OP_END: begin
          addr_ok_q <= 1'b0;
          rd_act    <= 1'b0;
        end
        OP_WADDR: begin
          if (!addr_ok_q) begin
            addr_ok_q <= 1'b1;
            wa_q      <= cur[AW-1:0];
          end
        end
        OP_RADDR: begin
          rd_act  <= 1'b1;
          rd_addr <= cur[AW-1:0];
          rd_hi   <= cur[4];
        end
        default: ;
      endcase
    end
  end

  assert_end_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && cur[7:5] == 3'b111) |=> (!rd_act && !wr_en));

  assert_addr_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ok_q && !(fresh && cur[7:5] == 3'b111)) |=> $stable(wa_q));
endmodule

// File: rtl/pp_nib_regbank.sv
module pp_nib_regbank
  import pp_nib_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_hi,
  input  logic [W/2-1:0]   wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_hi,
  output logic [W/2-1:0]   rd_nib
);
  localparam int NB = W / 2;
  logic [N-1:0][W-1:0] mem;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (wr_en && wr_addr == AW'(i)) begin
        if (wr_hi) mem[i][W-1:NB] <= wr_data;
        else       mem[i][NB-1:0] <= wr_data;
      end
    end
  end

  assign rd_nib = rd_hi ? mem[rd_addr][W-1:NB] : mem[rd_addr][NB-1:0];

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));

  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (($past(wr_hi) ? mem[$past(wr_addr)][W-1:NB]
                             : mem[$past(wr_addr)][NB-1:0]) == $past(wr_data)));
endmodule

// File: rtl/pp_nib_slave.sv
module pp_nib_slave
  import pp_nib_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_data,
  output logic [4:0] stat_o
);
  localparam int AW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [BYTE_W-1:0] cur, prev;
  logic              fresh, wr_en, wr_hi, rd_act, rd_hi;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [NIB_W-1:0]  wr_data, rd_nib;

  pp_nib_sync #(.W(BYTE_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(host_data),
    .cur(cur), .prev(prev), .fresh(fresh)
  );

  pp_nib_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .fresh(fresh),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_act(rd_act), .rd_addr(rd_addr), .rd_hi(rd_hi)
  );

  pp_nib_regbank #(.N(REG_COUNT), .W(BYTE_W), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_hi(wr_hi), .wr_data(wr_data), .rd_addr(rd_addr), .rd_hi(rd_hi),
    .rd_nib(rd_nib)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= rd_act ? {1'b1, rd_nib} : 5'd0;
  end

  assert_end_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && cur[7:5] == 3'b111) |=> ##1 (stat_o == 5'd0));

  assert_read_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && cur[7:5] == 3'b110) |=> ##1 stat_o[4]);
endmodule

// File: tb/pp_nib_slave_tb.sv
module pp_nib_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic [4:0] stat_o;
  logic [7:0] mdl [16];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pp_nib_slave u_dut (.clk(clk), .rst_n(rst_n), .host_data(host_data), .stat_o(stat_o));

  function automatic logic [7:0] put_nib(logic [7:0] old, bit hi, logic [3:0] v);
    return hi ? {v, old[3:0]} : {old[7:4], v};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    host_data = b;
    repeat (7) @(negedge clk);
  endtask

  task automatic rd_reg(logic [3:0] r, output logic [7:0] val);
    logic [3:0] lo;
    send({4'hE, r});
    send({4'hC, r});
    check(stat_o[4] == 1'b1, "R5 read flag", stat_o[4], 1);
    lo = stat_o[3:0];
    send({4'hD, r});
    check(stat_o[4] == 1'b1, "R5 read flag high", stat_o[4], 1);
    val = {stat_o[3:0], lo};
    send({4'hE, r});
    check(stat_o == 5'd0, "R1 end clears status", stat_o, 0);
  endtask

  task automatic chk_reg(logic [3:0] r, string tag);
    logic [7:0] v;
    rd_reg(r, v);
    check(v == mdl[r], tag, v, mdl[r]);
  endtask

  task automatic wr_byte(logic [3:0] r, logic [7:0] v, bit dup);
    send({4'hE, r});
    send({4'h4, r});
    if (dup) send({4'h4, r});
    send({4'h4, v[3:0]});
    send({4'h0, v[3:0]});
    if (dup) send({4'h0, v[3:0]});
    send({4'h0, v[7:4]});
    send({4'h1, v[7:4]});
    if (dup) send({4'h1, v[7:4]});
    send({4'hE, v[7:4]});
    mdl[r] = v;
  endtask

  task automatic wr_nib(logic [3:0] r, bit hi, logic [3:0] v, bit dup);
    logic [3:0] h = {3'b000, hi};
    send({3'b111, hi, r});
    send({3'b010, hi, r});
    send({3'b010, hi, v});
    if (dup) send({3'b010, hi, v});
    send({3'b000, hi, v});
    if (dup) send({3'b000, hi, v});
    send({3'b111, hi, v});
    mdl[r] = put_nib(mdl[r], h[0], v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(stat_o == 5'd0, "R8 status after reset", stat_o, 0);
    chk_reg(4'd0, "R8 reg0 reset");
    chk_reg(4'd15, "R8 reg15 reset");

    // R3/R4 directed byte write with repeated bytes (R6)
    wr_byte(4'd3, 8'hA5, 1'b1);
    chk_reg(4'd3, "R4 byte write reg3");
    wr_byte(4'd7, 8'h77, 1'b0);
    chk_reg(4'd7, "R4 byte write equal nibbles");
    // R3 single nibbles
    wr_nib(4'd3, 1'b1, 4'h2, 1'b1);
    chk_reg(4'd3, "R3 high nibble write");
    wr_nib(4'd3, 1'b0, 4'hC, 1'b0);
    chk_reg(4'd3, "R3 low nibble write");

    // R7: data with no address held
    send(8'hE9);
    send(8'h0A);
    send(8'h1B);
    send(8'hE9);
    chk_reg(4'd9, "R7 unaddressed data ignored");
    chk_reg(4'd10, "R7 reg10 unchanged");
    chk_reg(4'd11, "R7 reg11 unchanged");

    // R2: second 010 byte does not re-latch the address
    send(8'hE2);
    send(8'h42);
    send(8'h45);
    send(8'h05);
    send(8'hE5);
    mdl[2] = put_nib(mdl[2], 1'b0, 4'h5);
    chk_reg(4'd2, "R2 first address kept");
    chk_reg(4'd5, "R2 second address not latched");

    // R6: long hold of a commit byte
    send(8'hE4);
    send(8'h44);
    send(8'h46);
    send(8'h06);
    repeat (40) @(negedge clk);
    send(8'hE6);
    mdl[4] = put_nib(mdl[4], 1'b0, 4'h6);
    chk_reg(4'd4, "R6 held byte single effect");

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [3:0] r = 4'($urandom_range(0, 15));
      int kind = $urandom_range(0, 2);
      bit dup = 1'($urandom_range(0, 1));
      if (kind == 0) wr_byte(r, 8'($urandom), dup);
      else wr_nib(r, kind == 2, 4'($urandom), dup);
      if ((k % 4) == 3) chk_reg(4'($urandom_range(0, 15)), "R3 random readback");
    end
    for (int i = 0; i < 16; i++) chk_reg(4'(i), "R4 final sweep");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule